// File: doc/BRIEF.md
# Host Receive Burst Transfer Controller

This block hands received packet data from an on-chip staging buffer to a host, one bus-width transfer at a time, grouped in bursts. The host can pull a transfer in two ways. It can answer an active-low request with an active-low acknowledge, or it can read the receive data port register. Both ways consume the same data stream. Reads of any other register never touch that stream, so ordinary register traffic continues while a request is pending.

A packet is started by a strobe that loads its byte length. The block asks for service only when a packet is present in the ring and the staging buffer holds a complete burst. Near the end of the packet, a complete burst means whatever words are left, if fewer than the burst size. The block counts down the bytes still owed as transfers go by. At the transfer that finishes the packet data it can raise an end-of-packet interrupt. It then keeps the last burst open, marking each extra transfer as junk, until the byte offset in the packet sits on the alignment boundary for the host width. A staging pop strobe tells the fill logic which transfers carried real data.

Top module: `rx_host_burst`

## Requirements
- R1: `dreq_n` is high out of reset and whenever no packet is in progress. It falls only when `busy` is high and either the packet bytes are all sent (padding phase) or `pkt_avail` is high and `staged_words` is at least the smaller of the burst size and the number of words still owed.
- R2: A transfer happens in a cycle where `dreq_n` is low and either `dma_ack_n` is low or `host_rd` is high with `host_sel_port` high. A data transfer shows `pop` high in that same cycle, and the stream advances by one transfer whichever path the host used.
- R3: A host read with `host_sel_port` low, or any acknowledge or port read while `dreq_n` is high, moves no data: `pop` and `junk` stay low and the byte count does not change.
- R4: `burst_sel` codes 2'b00, 2'b01 and 2'b10 give bursts of 1, 2 and 4 transfers, and 2'b11 gives 4. `dreq_n` goes high in the cycle after the last transfer of a data burst and falls again only when R1 holds once more.
- R5: With `host16` high, each transfer moves 2 bytes. The final burst runs on past the packet end until the total number of bytes moved is a multiple of 8, so it carries 0 to 3 junk transfers (`junk` high, `pop` low).
- R6: With `host16` low, each transfer moves 4 bytes. The final burst runs on until the total is a multiple of 16, so it carries 0 to 3 junk transfers.
- R7: `eop_irq` pulses high for exactly one cycle, the cycle after the transfer that brings the bytes owed to zero or below, and only if `irq_en` is high at that transfer.
- R8: `pkt_start` loads `pkt_len` (at least 1) and raises `busy` only when `busy` is low. A strobe during a packet is ignored. `busy` falls after the last transfer of the aligned final burst.
- R9: In reset `dreq_n` is high and `busy`, `eop_irq`, `pop` and `junk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_avail | input | 1 | At least one received packet is in the ring |
| staged_words | input | CNT_W | Transfers currently held in the staging buffer |
| burst_sel | input | 2 | Burst length code |
| host16 | input | 1 | 1: 16-bit host, 0: 32-bit host |
| pkt_start | input | 1 | Begin a packet, load its length |
| pkt_len | input | LEN_W | Packet length in bytes |
| irq_en | input | 1 | Receive end-of-packet interrupt enable |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| host_rd | input | 1 | Host register read strobe |
| host_sel_port | input | 1 | The read addresses the receive data port |
| dreq_n | output | 1 | Active-low DMA request |
| pop | output | 1 | This transfer takes a word from staging |
| junk | output | 1 | This transfer is alignment padding |
| eop_irq | output | 1 | End-of-packet interrupt pulse |
| busy | output | 1 | A packet is in progress |

## Verification
The hardest case to reach is a final burst that must run past both the packet end and the burst size. For example, a one-byte packet in 32-bit mode with one-transfer bursts needs three junk transfers in the same open burst. The stimulus reaches it with short packet lengths in every width and burst-size combination. A slow staging fill makes the request wait on a partial last burst. Other-register reads are mixed in while the request is low, and a second start strobe is sent in the middle of a packet. Each case ends with a count of the junk transfers and of the interrupt pulses.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // Burst size decode: 00->1, 01->2, 10->4, 11->4.
  function automatic logic [2:0] beat_count(input logic [1:0] sel);
    case (sel)
      2'b00:   beat_count = 3'd1;
      2'b01:   beat_count = 3'd2;
      default: beat_count = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rxb_byte_track.sv
module rxb_byte_track #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host16,
  input  logic             irq_en,
  input  logic             pkt_start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             xfer,
  output logic             active,
  output logic             rem_pos,
  output logic [LEN_W-1:0] words_left,
  output logic             rem_pos_nxt,
  output logic             fin_nxt,
  output logic             eop_irq
);
  localparam int RW = LEN_W + 1;

  logic [RW-1:0] rem_q, rem_d, rem_after, step, rnd;
  logic [3:0]    offs_q, offs_d, offs_after, mask;
  logic          act_q, act_d, irq_q, irq_d;

  always_comb begin
    step       = host16 ? RW'(2) : RW'(4);
    mask       = host16 ? 4'd7 : 4'd15;
    rem_after  = rem_q - step;
    offs_after = (offs_q + step[3:0]) & mask;
    rem_pos    = !rem_q[RW-1] && (rem_q != '0);
    rem_pos_nxt = !rem_after[RW-1] && (rem_after != '0);
    fin_nxt    = xfer && !rem_pos_nxt && (offs_after == 4'd0);
    rnd        = rem_q + (host16 ? RW'(1) : RW'(3));
    words_left = host16 ? rnd[RW-1:1] : {1'b0, rnd[RW-1:2]};

    rem_d  = rem_q;
    offs_d = offs_q;
    act_d  = act_q;
    if (pkt_start && !act_q) begin
      act_d  = 1'b1;
      rem_d  = {1'b0, pkt_len};
      offs_d = 4'd0;
    end else if (xfer) begin
      rem_d  = rem_after;
      offs_d = offs_after;
      if (fin_nxt) act_d = 1'b0;
    end
    irq_d = xfer && rem_pos && !rem_pos_nxt && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      offs_q <= '0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      offs_q <= offs_d;
      act_q  <= act_d;
      irq_q  <= irq_d;
    end
  end

  assign active  = act_q;
  assign eop_irq = irq_q;

  AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7
  AST_END_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> (offs_q == 4'd0) && !rem_pos); // R5
endmodule

// File: rtl/rxb_beat_ctl.sv
module rxb_beat_ctl #(
  parameter int CNT_W = 6,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       burst_sel,
  input  logic             pkt_avail,
  input  logic [CNT_W-1:0] staged_words,
  input  logic             active,
  input  logic             rem_pos,
  input  logic [LEN_W-1:0] words_left,
  input  logic             xfer,
  input  logic             rem_pos_nxt,
  input  logic             fin_nxt,
  output logic             open
);
  logic [2:0] beats, need, beat_q, beat_d;
  logic       open_q, open_d, ready, last_beat, close, start;

  always_comb begin
    beats     = rxb_pkg::beat_count(burst_sel);
    need      = (words_left < LEN_W'(beats)) ? words_left[2:0] : beats;
    ready     = (CNT_W'(need) <= staged_words);
    last_beat = (beat_q == beats - 3'd1);
    close     = xfer && (fin_nxt || (rem_pos_nxt && last_beat));
    start     = !open_q && active && (!rem_pos || (pkt_avail && ready));

    open_d = open_q;
    beat_d = beat_q;
    if (close) begin
      open_d = 1'b0;
      beat_d = 3'd0;
    end else if (xfer) begin
      beat_d = (beat_q == 3'd7) ? beat_q : beat_q + 3'd1;
    end else if (start) begin
      open_d = 1'b1;
      beat_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      beat_q <= 3'd0;
    end else begin
      open_q <= open_d;
      beat_q <= beat_d;
    end
  end

  assign open = open_q;

  AST_REQ_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> active); // R1
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && rem_pos && $stable(burst_sel)) |-> (beat_q < beats)); // R4
endmodule

// File: rtl/rx_host_burst.sv
module rx_host_burst #(
  parameter int CNT_W       = 6,
  parameter int LEN_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_avail,
  input  logic [CNT_W-1:0] staged_words,
  input  logic [1:0]       burst_sel,
  input  logic             host16,
  input  logic             pkt_start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             irq_en,
  input  logic             dma_ack_n,
  input  logic             host_rd,
  input  logic             host_sel_port,
  output logic             dreq_n,
  output logic             pop,
  output logic             junk,
  output logic             eop_irq,
  output logic             busy
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe[SYNC_STAGES-1];

  logic             open, xfer, active, rem_pos, rem_pos_nxt, fin_nxt;
  logic [LEN_W-1:0] words_left;

  assign xfer = open && (!dma_ack_n || (host_rd && host_sel_port));

  rxb_byte_track #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_i_n), .host16(host16), .irq_en(irq_en),
    .pkt_start(pkt_start), .pkt_len(pkt_len), .xfer(xfer),
    .active(active), .rem_pos(rem_pos), .words_left(words_left),
    .rem_pos_nxt(rem_pos_nxt), .fin_nxt(fin_nxt), .eop_irq(eop_irq)
  );

  rxb_beat_ctl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_beat (
    .clk(clk), .rst_n(rst_i_n), .burst_sel(burst_sel), .pkt_avail(pkt_avail),
    .staged_words(staged_words), .active(active), .rem_pos(rem_pos),
    .words_left(words_left), .xfer(xfer), .rem_pos_nxt(rem_pos_nxt),
    .fin_nxt(fin_nxt), .open(open)
  );

  assign dreq_n = !open;
  assign pop    = xfer && rem_pos;
  assign junk   = xfer && !rem_pos;
  assign busy   = active;

  AST_POP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pop || junk) |-> !dreq_n); // R2
  AST_POP_JUNK_EXCL: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(pop && junk)); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> dreq_n); // R1
endmodule

// File: tb/test_rx_host_burst.sv
module test_rx_host_burst;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_avail, host16, pkt_start, irq_en, dma_ack_n, host_rd, host_sel_port, fill;
  logic [5:0] staged;
  logic [1:0] burst_sel;
  logic [11:0] pkt_len;
  logic       dreq_n, pop, junk, eop_irq, busy;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  rx_host_burst i_rx_host_burst (
    .clk(clk), .rst_n(rst_n), .pkt_avail(pkt_avail), .staged_words(staged),
    .burst_sel(burst_sel), .host16(host16), .pkt_start(pkt_start), .pkt_len(pkt_len),
    .irq_en(irq_en), .dma_ack_n(dma_ack_n), .host_rd(host_rd),
    .host_sel_port(host_sel_port), .dreq_n(dreq_n), .pop(pop), .junk(junk),
    .eop_irq(eop_irq), .busy(busy)
  );

  // Behavioural reference model.
  int m_rem, m_offs, m_beat;
  bit m_active, m_open, m_irq;

  function automatic bit host_wants();
    return !dma_ack_n || (host_rd && host_sel_port);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_open = 0; m_beat = 0; m_rem = 0; m_offs = 0; m_irq = 0;
      staged <= '0;
    end else begin
      int w, b, nb, wl, need, old;
      bit x, dpop, irqn, a0;
      w = host16 ? 2 : 4;
      b = host16 ? 8 : 16;
      nb = (burst_sel == 2'd0) ? 1 : (burst_sel == 2'd1) ? 2 : 4;
      a0 = m_active;
      x = m_open && host_wants();
      dpop = x && (m_rem > 0);
      irqn = 0;
      if (x) begin
        old = m_rem;
        m_rem -= w;
        m_offs = (m_offs + w) % b;
        if (old > 0 && m_rem <= 0 && irq_en) irqn = 1;
        if (m_rem <= 0 && m_offs == 0) begin
          m_open = 0; m_active = 0; m_beat = 0;
        end else if (m_rem > 0 && m_beat == nb - 1) begin
          m_open = 0; m_beat = 0;
        end else m_beat++;
      end else if (m_active && !m_open) begin
        wl = (m_rem + w - 1) / w;
        need = (wl < nb) ? wl : nb;
        if (m_rem <= 0 || (pkt_avail && int'(staged) >= need)) begin
          m_open = 1; m_beat = 0;
        end
      end
      if (pkt_start && !a0) begin
        m_active = 1; m_rem = int'(pkt_len); m_offs = 0;
      end
      m_irq = irqn;
      staged <= staged + 6'(fill) - 6'(dpop);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  int junk_seen, irq_seen;

  // Called just after inputs were driven; compares, then moves to next negedge.
  task automatic tick();
    bit x;
    #2;
    x = m_open && host_wants();
    chk(dreq_n == !m_open, "R1 R4 dreq_n", dreq_n, !m_open);
    chk(pop == (x && m_rem > 0), "R2 R3 pop", pop, x && m_rem > 0);
    chk(junk == (x && m_rem <= 0), "R5 R6 junk", junk, x && m_rem <= 0);
    chk(eop_irq == m_irq, "R7 eop_irq", eop_irq, m_irq);
    chk(busy == m_active, "R8 busy", busy, m_active);
    if (junk) junk_seen++;
    if (eop_irq) irq_seen++;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle_inputs();
    pkt_start = 0; dma_ack_n = 1; host_rd = 0; host_sel_port = 0; fill = 0;
  endtask

  task automatic run_pkt(input int len, input bit h16, input bit [1:0] bs,
                         input bit use_port, input bit ien, input int gap,
                         input int avail_delay, input bit spur);
    int w, b, words, padded, exp_junk, n;
    host16 = h16; burst_sel = bs; irq_en = ien; pkt_avail = 0;
    junk_seen = 0; irq_seen = 0;
    idle_inputs();
    pkt_len = 12'(len); pkt_start = 1;
    tick();
    n = 0;
    while (n < 3000) begin
      idle_inputs();
      pkt_avail = (n >= avail_delay);
      fill = ((n % gap) == 0) && (staged < 6'd40);
      if (spur && n == 4) begin pkt_start = 1; pkt_len = 12'd100; end
      if (!dreq_n) begin
        if ((n % 4) == 3) begin host_rd = 1; host_sel_port = 0; end
        else if (use_port) begin host_rd = 1; host_sel_port = 1; end
        else dma_ack_n = 0;
      end
      tick();
      n++;
      if (n > 4 && !busy && !m_active) break;
    end
    idle_inputs();
    tick(); tick();
    w = h16 ? 2 : 4; b = h16 ? 8 : 16;
    words = (len + w - 1) / w;
    padded = ((words * w + b - 1) / b) * b;
    exp_junk = (padded - words * w) / w;
    if (h16) chk(junk_seen == exp_junk, "R5 junk transfers", junk_seen, exp_junk);
    else     chk(junk_seen == exp_junk, "R6 junk transfers", junk_seen, exp_junk);
    chk(irq_seen == (ien ? 1 : 0), "R7 irq count", irq_seen, ien ? 1 : 0);
    chk(busy == 0, "R8 idle after packet", busy, 0);
  endtask

  initial begin
    rst_n = 0;
    pkt_avail = 0; host16 = 0; burst_sel = 0; irq_en = 0; pkt_len = '0;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    #2;
    // R9: reset state
    chk(dreq_n == 1, "R9 dreq_n in reset", dreq_n, 1);
    chk(busy == 0, "R9 busy in reset", busy, 0);
    chk(eop_irq == 0, "R9 eop_irq in reset", eop_irq, 0);
    chk(pop == 0 && junk == 0, "R9 pop/junk in reset", pop | junk, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    run_pkt(20, 0, 2'b10, 0, 1, 1, 0, 0);   // R6 R4: 4-beat DMA bursts, 3 junk
    run_pkt(9,  1, 2'b00, 1, 1, 1, 0, 0);   // R5 R2: port reads, 1-beat
    run_pkt(64, 0, 2'b11, 1, 0, 2, 6, 0);   // R4 R1: code 11, late pkt_avail, no irq
    run_pkt(3,  1, 2'b01, 0, 1, 3, 0, 0);   // R5: slow fill, 2 junk
    run_pkt(1,  0, 2'b00, 0, 1, 1, 0, 0);   // R6: one byte, 3 junk in one burst
    run_pkt(8,  0, 2'b00, 1, 1, 2, 0, 1);   // R8: start strobe during packet ignored
    run_pkt(37, 1, 2'b10, 0, 0, 2, 3, 0);   // R3 R5: mixed register reads
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule